// File: doc/BRIEF.md
# Relocatable Address Decoder with Paged Program Window

This block sits beside a 16-bit CPU and turns each address into exactly one select among four on-chip targets or the external bus. The four on-chip targets are a control-register block, SRAM, data EEPROM and program flash. Software can move three of the targets at run time: the register block, the SRAM and the EEPROM can each be placed on any 2 KB boundary. A small configuration port sets each base. When two relocated regions overlap, a fixed priority order chooses the target.

The upper half of the 16-bit space is program space. Addresses 0x8000 to 0xBFFF form a 16 KB window, and a 6-bit page register picks which of 64 pages appears there. The two 16 KB quarters on either side of the window are tied to pages 0x3E and 0x3F. For every access the block also produces a 20-bit linear address, made of the effective page on bits 19:14 and the low 14 CPU address bits. The external bus uses this address for targets that are not on chip, and paged flash can use it too.

The decode is combinational from the address and the registered configuration. A configuration write therefore changes the map from the clock edge that ends the write cycle onward.

Top module: `memmap_decode`

## Requirements
- R1: After reset the register-block base is 0x0000, the SRAM base is 0x3800, the EEPROM base is 0x1000 with its decode enabled, and the page register is 0x00.
- R2: A write with `cfg_sel`=0 sets the register-block base to `cfg_wdata[7:3]` × 0x800. With the default 2 KB size, an address selects the register block when its bits 15:11 equal that value.
- R3: A write with `cfg_sel`=1 sets address bits 15:11 of the 2 KB SRAM region from `cfg_wdata[7:3]`.
- R4: A write with `cfg_sel`=2 sets the EEPROM base from `cfg_wdata[7:3]` and its enable from `cfg_wdata[0]`. While the enable is 0, `sel_eep` is never asserted.
- R5: Exactly one of `sel_reg`, `sel_sram`, `sel_eep`, `sel_flash` and `sel_ext` is high in every cycle. When regions overlap, the winner follows this order: register block, then SRAM, then EEPROM, then flash, then external.
- R6: A configuration write does not affect the decode in the cycle in which `cfg_we` is high. It takes effect from the following cycle.
- R7: For addresses 0x8000–0xBFFF, `xaddr` = page × 0x4000 + (address − 0x8000). That is, the page register drives bits 19:14 and address bits 13:0 drive bits 13:0.
- R8: Addresses 0x4000–0x7FFF use the fixed page 0x3E, and addresses 0xC000–0xFFFF use the fixed page 0x3F. Addresses 0x0000–0x3FFF use page 0x00.
- R9: An address of 0x4000 or above that no relocatable region claims selects flash when its effective page is 0x30 or higher. Otherwise it selects the external bus.
- R10: An address that matches no on-chip target asserts `sel_ext`. `xaddr` is driven for every address.
- R11: A write with `cfg_sel`=3 loads the page from `cfg_wdata[5:0]`. Bits 7:6 are ignored. Cycles without `cfg_we` leave all configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target register: 0 register-block base, 1 SRAM base, 2 EEPROM base/enable, 3 page |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_addr | input | 16 | CPU address to decode |
| sel_reg | output | 1 | Register block selected |
| sel_sram | output | 1 | SRAM selected |
| sel_eep | output | 1 | EEPROM selected |
| sel_flash | output | 1 | On-chip flash selected |
| sel_ext | output | 1 | External bus selected |
| xaddr | output | 20 | Extended linear address |

## Verification
The bench probes an address in the same cycle as a relocation write and checks that the old map still applies. A design that registers the write combinationally would switch targets one cycle early. The bench stacks the register block, the SRAM and the EEPROM on top of the fixed flash quarter. A wrong priority chain would then raise the wrong select, or two selects at once. It also tries pages 0x2F and 0x30 on both sides of the flash threshold. It disables the EEPROM while keeping its base, so an ignored enable bit shows up as a stray EEPROM select. It checks the extended address at the window edges and in the fixed quarters, which exposes a swapped fixed page or an offset that was not rebased.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
    localparam int ADDR_W  = 16;
    localparam int XADDR_W = 20;
    localparam int PAGE_W  = 6;
    localparam int BASE_W  = 5;
    localparam int DATA_W  = 8;
    localparam int OFS_W   = XADDR_W - PAGE_W;
    localparam int NREGION = 3;

    typedef enum logic [1:0] {
        CFG_REGBLK = 2'd0,
        CFG_SRAM   = 2'd1,
        CFG_EEPROM = 2'd2,
        CFG_PAGE   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [BASE_W-1:0] reg_base;
        logic [BASE_W-1:0] ram_base;
        logic [BASE_W-1:0] ee_base;
        logic              ee_en;
        logic [PAGE_W-1:0] page;
    } map_cfg_t;

    typedef struct packed {
        logic ext;
        logic flash;
        logic eep;
        logic sram;
        logic regblk;
    } sel_vec_t;
endpackage

// File: rtl/memmap_cfg_regs.sv
module memmap_cfg_regs
    import memmap_pkg::*;
#(
    parameter logic [BASE_W-1:0] REG_BASE_RST = 5'h00,
    parameter logic [BASE_W-1:0] RAM_BASE_RST = 5'h07,
    parameter logic [BASE_W-1:0] EE_BASE_RST  = 5'h02,
    parameter logic              EE_EN_RST    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output map_cfg_t          cfg_q
);
    localparam map_cfg_t CFG_RST = '{
        reg_base: REG_BASE_RST,
        ram_base: RAM_BASE_RST,
        ee_base:  EE_BASE_RST,
        ee_en:    EE_EN_RST,
        page:     '0
    };

    map_cfg_t  cfg_d;
    cfg_sel_e  sel_e;

    assign sel_e = cfg_sel_e'(cfg_sel);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            unique case (sel_e)
                CFG_REGBLK: cfg_d.reg_base = cfg_wdata[DATA_W-1 -: BASE_W];
                CFG_SRAM:   cfg_d.ram_base = cfg_wdata[DATA_W-1 -: BASE_W];
                CFG_EEPROM: begin
                    cfg_d.ee_base = cfg_wdata[DATA_W-1 -: BASE_W];
                    cfg_d.ee_en   = cfg_wdata[0];
                end
                CFG_PAGE:   cfg_d.page = cfg_wdata[PAGE_W-1:0];
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    // R6: an SRAM base write shows up in the register on the following cycle
    p_base_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd1) |=> (cfg_q.ram_base == $past(cfg_wdata[DATA_W-1 -: BASE_W])));

    // R11: no strobe, no change
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));
endmodule

// File: rtl/memmap_region_match.sv
module memmap_region_match
    import memmap_pkg::*;
#(
    parameter int SIZE_LOG2 = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic              en,
    output logic              hit
);
    localparam int PAD_W = ADDR_W - BASE_W;

    logic [ADDR_W-1:0] base_full;

    assign base_full = {base, {PAD_W{1'b0}}};
    assign hit = en && (addr[ADDR_W-1:SIZE_LOG2] == base_full[ADDR_W-1:SIZE_LOG2]);
endmodule

// File: rtl/memmap_page_xlate.sv
module memmap_page_xlate
    import memmap_pkg::*;
#(
    parameter logic [PAGE_W-1:0] LOW_FIX_PAGE  = 6'h3E,
    parameter logic [PAGE_W-1:0] HIGH_FIX_PAGE = 6'h3F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [PAGE_W-1:0]  page,
    output logic [PAGE_W-1:0]  page_eff,
    output logic [XADDR_W-1:0] xaddr
);
    always_comb begin
        unique case (addr[ADDR_W-1 -: 2])
            2'b00:   page_eff = '0;
            2'b01:   page_eff = LOW_FIX_PAGE;
            2'b10:   page_eff = page;
            default: page_eff = HIGH_FIX_PAGE;
        endcase
    end

    assign xaddr = {page_eff, addr[OFS_W-1:0]};

    // R7: window accesses carry the page register on the top address bits
    p_window_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1 -: 2] == 2'b10) |-> (xaddr[XADDR_W-1 -: PAGE_W] == page));

    // R8: the top quarter is always the last page
    p_fixed_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1 -: 2] == 2'b11) |-> (xaddr[XADDR_W-1 -: PAGE_W] == HIGH_FIX_PAGE));
endmodule

// File: rtl/memmap_decode.sv
module memmap_decode
    import memmap_pkg::*;
#(
    parameter int                REG_SIZE_LOG2  = 11,
    parameter int                RAM_SIZE_LOG2  = 11,
    parameter int                EE_SIZE_LOG2   = 11,
    parameter logic [PAGE_W-1:0] FLASH_PAGE_MIN = 6'h30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [7:0]         cfg_wdata,
    input  logic [15:0]        cpu_addr,
    output logic               sel_reg,
    output logic               sel_sram,
    output logic               sel_eep,
    output logic               sel_flash,
    output logic               sel_ext,
    output logic [19:0]        xaddr
);
    map_cfg_t           cfg_q;
    logic [PAGE_W-1:0]  page_eff;
    logic [BASE_W-1:0]  rbase [NREGION];
    logic               ren   [NREGION];
    logic [NREGION-1:0] rhit;
    logic               flash_ok;
    sel_vec_t           sel;

    memmap_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q)
    );

    assign rbase[0] = cfg_q.reg_base;
    assign rbase[1] = cfg_q.ram_base;
    assign rbase[2] = cfg_q.ee_base;
    assign ren[0]   = 1'b1;
    assign ren[1]   = 1'b1;
    assign ren[2]   = cfg_q.ee_en;

    for (genvar g = 0; g < NREGION; g++) begin : g_region
        localparam int SZ = (g == 0) ? REG_SIZE_LOG2 :
                            (g == 1) ? RAM_SIZE_LOG2 : EE_SIZE_LOG2;
        memmap_region_match #(.SIZE_LOG2(SZ)) u_match (
            .addr (cpu_addr),
            .base (rbase[g]),
            .en   (ren[g]),
            .hit  (rhit[g])
        );
    end

    memmap_page_xlate u_xlate (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cpu_addr),
        .page     (cfg_q.page),
        .page_eff (page_eff),
        .xaddr    (xaddr)
    );

    assign flash_ok = (cpu_addr[ADDR_W-1 -: 2] != 2'b00) && (page_eff >= FLASH_PAGE_MIN);

    always_comb begin
        sel = '0;
        if      (rhit[0]) sel.regblk = 1'b1;
        else if (rhit[1]) sel.sram   = 1'b1;
        else if (rhit[2]) sel.eep    = 1'b1;
        else if (flash_ok) sel.flash = 1'b1;
        else              sel.ext    = 1'b1;
    end

    assign sel_reg   = sel.regblk;
    assign sel_sram  = sel.sram;
    assign sel_eep   = sel.eep;
    assign sel_flash = sel.flash;
    assign sel_ext   = sel.ext;

    // R5: one and only one target per cycle
    p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_reg, sel_sram, sel_eep, sel_flash, sel_ext}) == 1);

    // R5: the register block beats SRAM wherever both bases cover the address
    p_reg_over_ram_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.reg_base == cfg_q.ram_base && REG_SIZE_LOG2 == RAM_SIZE_LOG2 &&
         cpu_addr[ADDR_W-1 -: BASE_W] == cfg_q.ram_base) |-> !sel_sram);

    // R4: a disabled EEPROM never responds
    p_ee_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.ee_en |-> !sel_eep);

    // R9: flash only answers at or above the page threshold
    p_flash_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_flash |-> (xaddr[19 -: PAGE_W] >= FLASH_PAGE_MIN));

    // R10: external accesses come from unclaimed low space or low pages
    p_ext_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ext |-> (cpu_addr[15:14] == 2'b00 || xaddr[19 -: PAGE_W] < FLASH_PAGE_MIN));
endmodule

// File: tb/memmap_decode_tb.sv
module memmap_decode_tb;
    typedef struct {
        logic [4:0]  sel;
        logic [19:0] xa;
        logic [15:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = 0;
    logic [7:0]  cfg_wdata = 0;
    logic [15:0] cpu_addr = 0;
    logic        sel_reg, sel_sram, sel_eep, sel_flash, sel_ext;
    logic [19:0] xaddr;

    int checks = 0;
    int failed = 0;
    bit done = 0;

    logic [4:0] m_reg, m_ram, m_ee;
    logic       m_een;
    logic [5:0] m_page;

    exp_t q[$];
    exp_t it;

    always #2 clk = ~clk;

    memmap_decode u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .sel_reg(sel_reg),
        .sel_sram(sel_sram), .sel_eep(sel_eep), .sel_flash(sel_flash),
        .sel_ext(sel_ext), .xaddr(xaddr)
    );

    function automatic exp_t model(input logic [15:0] a, input string tag);
        exp_t e;
        logic [5:0] pg;
        case (a[15:14])
            2'b00:   pg = 6'h00;
            2'b01:   pg = 6'h3E;
            2'b10:   pg = m_page;
            default: pg = 6'h3F;
        endcase
        e.xa = {pg, a[13:0]};
        e.addr = a;
        e.tag = tag;
        if (a[15:11] == m_reg)                e.sel = 5'b00001;
        else if (a[15:11] == m_ram)           e.sel = 5'b00010;
        else if (m_een && a[15:11] == m_ee)   e.sel = 5'b00100;
        else if (a >= 16'h4000 && pg >= 6'h30) e.sel = 5'b01000;
        else                                   e.sel = 5'b10000;
        return e;
    endfunction

    task automatic model_write(input logic [1:0] s, input logic [7:0] d);
        case (s)
            2'd0: m_reg = d[7:3];
            2'd1: m_ram = d[7:3];
            2'd2: begin m_ee = d[7:3]; m_een = d[0]; end
            default: m_page = d[5:0];
        endcase
    endtask

    task automatic probe(input logic [15:0] a, input string tag);
        @(posedge clk); #1;
        cpu_addr = a;
        q.push_back(model(a, tag));
    endtask

    // write plus a probe in the same cycle: old map expected (R6)
    task automatic write_probe(input logic [1:0] s, input logic [7:0] d,
                               input logic [15:0] a, input string tag);
        @(posedge clk); #1;
        cfg_we = 1; cfg_sel = s; cfg_wdata = d; cpu_addr = a;
        q.push_back(model(a, tag));
        @(posedge clk); #1;
        cfg_we = 0;
        model_write(s, d);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
        model_write(s, d);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if ({sel_ext, sel_flash, sel_eep, sel_sram, sel_reg} !== it.sel || xaddr !== it.xa) begin
                failed++;
                $display("FAIL %s addr=%h sel=%b xaddr=%h expected sel=%b xaddr=%h",
                         it.tag, it.addr, {sel_ext, sel_flash, sel_eep, sel_sram, sel_reg},
                         xaddr, it.sel, it.xa);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failed++;
            $display("FAIL watchdog expired, got hang expected completion");
            $display("%0d/%0d checks passed", checks - failed, checks);
            $finish;
        end
    end

    initial begin
        m_reg = 5'h00; m_ram = 5'h07; m_ee = 5'h02; m_een = 1'b1; m_page = 6'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset map
        probe(16'h0000, "R1 reg default");
        probe(16'h3800, "R1 sram default");
        probe(16'h17FF, "R1 eeprom default");
        probe(16'h8000, "R1 page zero");
        probe(16'h2000, "R10 unclaimed low space");

        // R6 + R2: relocate register block to 0x2000
        write_probe(2'd0, 8'h20, 16'h2000, "R6 old map during write");
        probe(16'h2000, "R2 reg at new base");
        probe(16'h27FF, "R2 reg top byte");
        probe(16'h2800, "R2 just above reg");
        probe(16'h0000, "R2 old base vacated");

        // R3 + R5: SRAM over fixed flash quarter
        cfg_write(2'd1, 8'h40);
        probe(16'h4000, "R3 sram over flash");
        probe(16'h47FF, "R3 sram top");
        probe(16'h4800, "R8 flash low fixed page");
        probe(16'h3800, "R3 old sram base vacated");

        // R5: register block over SRAM
        cfg_write(2'd0, 8'h40);
        probe(16'h4123, "R5 reg beats sram");

        // R4: eeprom enable bit
        cfg_write(2'd2, 8'h10);
        probe(16'h1000, "R4 eeprom disabled");
        cfg_write(2'd2, 8'h51);
        probe(16'h5000, "R5 eeprom over flash");
        cfg_write(2'd2, 8'h50);
        probe(16'h5000, "R4 disabled keeps base");

        // R7 / R9: page window
        cfg_write(2'd3, 8'h38);
        probe(16'h9003, "R7 window page 38");
        cfg_write(2'd3, 8'h20);
        probe(16'hA003, "R7 window page 20 external");
        cfg_write(2'd3, 8'h2F);
        probe(16'h8000, "R9 page 2F external");
        cfg_write(2'd3, 8'h30);
        probe(16'h8000, "R9 page 30 flash");
        cfg_write(2'd3, 8'hFF);
        probe(16'hBFFF, "R11 page upper bits ignored");
        probe(16'hC000, "R8 top quarter");
        probe(16'hFFFF, "R8 last byte");
        probe(16'h7FFF, "R8 low quarter end");

        // R5: SRAM inside the window
        write_probe(2'd1, 8'h80, 16'h8000, "R6 window before sram move");
        probe(16'h8000, "R5 sram inside window");

        // R11: idle cycles hold config
        repeat (5) @(posedge clk);
        probe(16'h8000, "R11 config held");

        // sweep of the whole space
        for (int i = 0; i < 64; i++) probe(16'(i * 16'h0400), "R10 sweep");

        // R2: relocate register block to the very top
        cfg_write(2'd0, 8'hF8);
        probe(16'hF800, "R2 reg top boundary");
        probe(16'hF7FF, "R5 below reg is flash");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - failed, checks);
        $finish;
    end
endmodule